// File: doc/BRIEF.md
# Hash Engine Control Front-End

This block is the register-facing control layer of a multi-algorithm hash engine. Software programs a source address, a digest destination address, a key address and a byte count through a 32-bit register bus, then writes a command word. That command write is what launches a job. The block decodes the algorithm and output-format bits of the command and hands a frozen copy of the job configuration to the hash datapath with a single-cycle start pulse. It then reports busy until the datapath signals done.

Completion is recorded in a sticky status flag that software clears by writing a one to it. A separate input-overflow error flag, raised by the datapath, stays set until the block itself is reset. A command written while a job is running is dropped. A command whose algorithm field matches no supported hash finishes at once, without starting the datapath. The compression logic and the memory transfers sit outside this block.

Top module: `hash_ctl_frontend`

## Requirements
- R1: While reset is held high, and after it is released, every register reads zero, `dp_start` is low and all three status bits (busy bit 0, done bit 9, overflow bit 23 of offset 0x1C) are clear.
- R2: Offsets 0x20 (source), 0x24 (destination), 0x28 (key), 0x2C (length) and 0x30 (command) read back the last value accepted into them. Any other offset reads zero, and status bits other than 0, 9 and 23 read zero.
- R3: A command write at offset 0x30 while idle, with a supported algorithm, sets busy and drives `dp_start` high for exactly one cycle. Both are visible in the cycle after the write.
- R4: The algorithm code on `dp_algo` is taken from command bits {10,6,5,4}, as follows. 0010 gives SHA-1 and code 1. 0100 gives SHA-224 and code 2. 0101 gives SHA-256 and code 3. 1110 gives SHA-384 and code 4. 0110 gives SHA-512 and code 5.
- R5: The addresses, the length, the algorithm and the flags sent to the datapath are those in force at launch. The flags are `dp_be_out` from command bit 3, `dp_md5_le` from bit 2 and `dp_sg_mode` from bit 18. None of these outputs changes while busy, even when the registers are rewritten.
- R6: A command write while busy is ignored. The command register keeps its value, no start pulse is issued and busy stays set.
- R7: When `dp_done` is sampled high while busy, busy is clear and the done flag is set in the next cycle. `dp_done` while idle leaves the done flag unchanged.
- R8: Writing status with bit 9 set clears the done flag, and writing bit 9 as zero leaves it. If a completion and a clear fall in the same cycle, the flag ends set.
- R9: `dp_overflow` sets status bit 23, and the bit stays set through any status write. Only reset clears it.
- R10: A command whose bits {10,6,5,4} match none of the R4 encodings produces no start pulse and leaves busy clear. It sets the done flag in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset (writes and reads) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dp_done | input | 1 | Datapath finished the current job |
| dp_overflow | input | 1 | Datapath detected an input-data overflow |
| dp_start | output | 1 | One-cycle job launch pulse |
| dp_algo | output | 3 | Algorithm code of the running job |
| dp_src_addr | output | 32 | Source address of the job |
| dp_dst_addr | output | 32 | Digest destination address of the job |
| dp_key_addr | output | 32 | Key address of the job |
| dp_len | output | 32 | Byte length of the job |
| dp_be_out | output | 1 | Big-endian digest output requested |
| dp_md5_le | output | 1 | Little-endian MD5 output requested |
| dp_sg_mode | output | 1 | Source is a scatter-gather list |

## Verification
Register reads are combinational, so a written value or a flag change is due one clock edge after the write or the datapath event, and the bench samples it at the following falling edge. The start pulse, busy and the frozen job configuration all appear one edge after the command write. The start pulse is gone one edge later. The bench drives every input on a falling edge and checks outputs at falling edges only. Each result is therefore read exactly one register stage after the edge that caused it, with no race against that edge.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;

    localparam int REG_W = 32;

    // register byte offsets
    localparam int OFS_STATUS   = 'h1C;
    localparam int OFS_CFG_BASE = 'h20;   // src, dst, key, len in steps of 4
    localparam int NUM_CFG      = 4;
    localparam int OFS_CMD      = 'h30;

    localparam int CFG_SRC = 0;
    localparam int CFG_DST = 1;
    localparam int CFG_KEY = 2;
    localparam int CFG_LEN = 3;

    // status bit positions
    localparam int STS_BUSY = 0;
    localparam int STS_DONE = 9;
    localparam int STS_OVF  = 23;

    // command bit positions
    localparam int CMD_MD5_LE = 2;
    localparam int CMD_SHA_BE = 3;
    localparam int CMD_ALG_A  = 4;
    localparam int CMD_ALG_B  = 5;
    localparam int CMD_ALG_C  = 6;
    localparam int CMD_ALG_D  = 10;
    localparam int CMD_SG     = 18;

    typedef enum logic [2:0] {
        ALG_NONE   = 3'd0,
        ALG_SHA1   = 3'd1,
        ALG_SHA224 = 3'd2,
        ALG_SHA256 = 3'd3,
        ALG_SHA384 = 3'd4,
        ALG_SHA512 = 3'd5
    } hash_alg_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] key;
        logic [REG_W-1:0] len;
        hash_alg_e        alg;
        logic             sha_be;
        logic             md5_le;
        logic             sg_mode;
    } job_cfg_t;

    function automatic hash_alg_e decode_alg(input logic [REG_W-1:0] cmd);
        hash_alg_e a;
        case ({cmd[CMD_ALG_D], cmd[CMD_ALG_C], cmd[CMD_ALG_B], cmd[CMD_ALG_A]})
            4'b0010: a = ALG_SHA1;
            4'b0100: a = ALG_SHA224;
            4'b0101: a = ALG_SHA256;
            4'b0110: a = ALG_SHA512;
            4'b1110: a = ALG_SHA384;
            default: a = ALG_NONE;
        endcase
        return a;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic busy,
                                                      input logic done,
                                                      input logic ovf);
        logic [REG_W-1:0] s;
        s           = '0;
        s[STS_BUSY] = busy;
        s[STS_DONE] = done;
        s[STS_OVF]  = ovf;
        return s;
    endfunction

endpackage

// File: rtl/hash_ctl_regfile.sv
module hash_ctl_regfile
    import hash_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done_flag,
    input  logic              ovf_flag,
    output logic [REG_W-1:0]  cfg_regs [NUM_CFG],
    output logic              cmd_launch,
    output logic              clr_done,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    logic [REG_W-1:0] cmd_q;
    logic             cmd_hit;

    // one register per configuration word, each decoded from its own offset
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] A_THIS = ADDR_W'(OFS_CFG_BASE + 4 * i);
        logic hit;
        assign hit = wr_en && (addr == A_THIS);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_regs[i] <= '0;
            end else if (hit) begin
                cfg_regs[i] <= wdata;
            end
        end
    end

    assign cmd_hit    = wr_en && (addr == A_CMD);
    assign cmd_launch = cmd_hit && !busy;
    assign clr_done   = wr_en && (addr == A_STATUS) && wdata[STS_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_launch) begin
            cmd_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_STATUS) begin
            rdata = pack_status(busy, done_flag, ovf_flag);
        end
        if (addr == A_CMD) begin
            rdata = cmd_q;
        end
        for (int i = 0; i < NUM_CFG; i++) begin
            if (addr == ADDR_W'(OFS_CFG_BASE + 4 * i)) begin
                rdata = cfg_regs[i];
            end
        end
    end

endmodule

// File: rtl/hash_ctl_decode.sv
module hash_ctl_decode
    import hash_ctl_pkg::*;
(
    input  logic [REG_W-1:0] cmd_word,
    input  logic [REG_W-1:0] cfg_regs [NUM_CFG],
    output job_cfg_t         job,
    output logic             alg_ok
);

    hash_alg_e alg;

    assign alg    = decode_alg(cmd_word);
    assign alg_ok = (alg != ALG_NONE);

    always_comb begin
        job         = '0;
        job.src     = cfg_regs[CFG_SRC];
        job.dst     = cfg_regs[CFG_DST];
        job.key     = cfg_regs[CFG_KEY];
        job.len     = cfg_regs[CFG_LEN];
        job.alg     = alg;
        job.sha_be  = cmd_word[CMD_SHA_BE];
        job.md5_le  = cmd_word[CMD_MD5_LE];
        job.sg_mode = cmd_word[CMD_SG];
    end

endmodule

// File: rtl/hash_ctl_seq.sv
module hash_ctl_seq
    import hash_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  logic     alg_ok,
    input  job_cfg_t job_in,
    input  logic     clr_done,
    input  logic     dp_done,
    input  logic     dp_overflow,
    output logic     busy,
    output logic     done_flag,
    output logic     ovf_flag,
    output logic     start,
    output job_cfg_t job_out
);

    seq_state_e state_q;
    logic       done_q;
    logic       ovf_q;
    logic       start_q;
    job_cfg_t   job_q;
    logic       finish_now;

    // a job ends either through the datapath or at once for a bad encoding
    always_comb begin
        finish_now = 1'b0;
        if (state_q == SEQ_RUN && dp_done) begin
            finish_now = 1'b1;
        end
        if (state_q == SEQ_IDLE && launch && !alg_ok) begin
            finish_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
            start_q <= 1'b0;
            job_q   <= '0;
        end else begin
            start_q <= 1'b0;
            if (dp_overflow) begin
                ovf_q <= 1'b1;
            end
            // clear first so that a same-cycle completion wins
            if (clr_done) begin
                done_q <= 1'b0;
            end
            if (finish_now) begin
                done_q <= 1'b1;
            end
            case (state_q)
                SEQ_IDLE: begin
                    if (launch && alg_ok) begin
                        job_q   <= job_in;
                        start_q <= 1'b1;
                        state_q <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (dp_done) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == SEQ_RUN);
    assign done_flag = done_q;
    assign ovf_flag  = ovf_q;
    assign start     = start_q;
    assign job_out   = job_q;

endmodule

// File: rtl/hash_ctl_frontend.sv
module hash_ctl_frontend
    import hash_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dp_done,
    input  logic              dp_overflow,
    output logic              dp_start,
    output logic [2:0]        dp_algo,
    output logic [31:0]       dp_src_addr,
    output logic [31:0]       dp_dst_addr,
    output logic [31:0]       dp_key_addr,
    output logic [31:0]       dp_len,
    output logic              dp_be_out,
    output logic              dp_md5_le,
    output logic              dp_sg_mode
);

    logic [REG_W-1:0] cfg_regs [NUM_CFG];
    logic             cmd_launch;
    logic             clr_done;
    logic             busy_w;
    logic             done_w;
    logic             ovf_w;
    logic             alg_ok;
    job_cfg_t         job_new;
    job_cfg_t         job_run;

    hash_ctl_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy_w),
        .done_flag  (done_w),
        .ovf_flag   (ovf_w),
        .cfg_regs   (cfg_regs),
        .cmd_launch (cmd_launch),
        .clr_done   (clr_done),
        .rdata      (reg_rdata)
    );

    // the command being written, not the stored one, defines the new job
    hash_ctl_decode u_dec (
        .cmd_word (reg_wdata),
        .cfg_regs (cfg_regs),
        .job      (job_new),
        .alg_ok   (alg_ok)
    );

    hash_ctl_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (cmd_launch),
        .alg_ok      (alg_ok),
        .job_in      (job_new),
        .clr_done    (clr_done),
        .dp_done     (dp_done),
        .dp_overflow (dp_overflow),
        .busy        (busy_w),
        .done_flag   (done_w),
        .ovf_flag    (ovf_w),
        .start       (dp_start),
        .job_out     (job_run)
    );

    assign dp_algo     = job_run.alg;
    assign dp_src_addr = job_run.src;
    assign dp_dst_addr = job_run.dst;
    assign dp_key_addr = job_run.key;
    assign dp_len      = job_run.len;
    assign dp_be_out   = job_run.sha_be;
    assign dp_md5_le   = job_run.md5_le;
    assign dp_sg_mode  = job_run.sg_mode;

endmodule

// File: rtl/hash_ctl_checker.sv
module hash_ctl_checker
    import hash_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              dp_done,
    input logic              dp_overflow,
    input logic              dp_start,
    input logic [2:0]        dp_algo,
    input logic [31:0]       dp_src_addr,
    input logic [31:0]       dp_len,
    input logic              busy,
    input logic              done_flag,
    input logic              ovf_flag
);

    logic cmd_wr;
    logic done_clr_wr;

    assign cmd_wr      = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
    assign done_clr_wr = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS)) && reg_wdata[STS_DONE];

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        dp_start |-> busy);

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !dp_start) |-> ($stable(dp_src_addr) && $stable(dp_len) && $stable(dp_algo)));

    assert_busy_cmd_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> !dp_start);

    assert_done_ends_job_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && dp_done) |=> (!busy && done_flag));

    assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && dp_done && !done_flag && !reg_wr) |=> !done_flag);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !done_clr_wr) |=> done_flag);

    assert_ovf_set_R9: assert property (@(posedge clk) disable iff (rst)
        dp_overflow |=> ovf_flag);

    assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

endmodule

bind hash_ctl_frontend hash_ctl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .dp_done     (dp_done),
    .dp_overflow (dp_overflow),
    .dp_start    (dp_start),
    .dp_algo     (dp_algo),
    .dp_src_addr (dp_src_addr),
    .dp_len      (dp_len),
    .busy        (busy_w),
    .done_flag   (done_w),
    .ovf_flag    (ovf_w)
);

// File: tb/hash_ctl_frontend_bench.sv
`timescale 1ns/1ps
module hash_ctl_frontend_bench;

    localparam int AW = 8;
    localparam logic [7:0] A_STS = 8'h1C;
    localparam logic [7:0] A_SRC = 8'h20;
    localparam logic [7:0] A_DST = 8'h24;
    localparam logic [7:0] A_KEY = 8'h28;
    localparam logic [7:0] A_LEN = 8'h2C;
    localparam logic [7:0] A_CMD = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dp_done = 1'b0;
    logic        dp_overflow = 1'b0;
    logic        dp_start;
    logic [2:0]  dp_algo;
    logic [31:0] dp_src_addr, dp_dst_addr, dp_key_addr, dp_len;
    logic        dp_be_out, dp_md5_le, dp_sg_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hash_ctl_frontend #(.ADDR_W(AW)) u_hash_ctl_frontend (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_done(dp_done),
        .dp_overflow(dp_overflow), .dp_start(dp_start), .dp_algo(dp_algo),
        .dp_src_addr(dp_src_addr), .dp_dst_addr(dp_dst_addr),
        .dp_key_addr(dp_key_addr), .dp_len(dp_len), .dp_be_out(dp_be_out),
        .dp_md5_le(dp_md5_le), .dp_sg_mode(dp_sg_mode)
    );

    // R4 table: index 0..4 -> SHA-1, SHA-224, SHA-256, SHA-384, SHA-512
    function automatic logic [31:0] alg_bits(input int idx);
        case (idx)
            0: return 32'h0000_0020;
            1: return 32'h0000_0040;
            2: return 32'h0000_0050;
            3: return 32'h0000_0460;
            default: return 32'h0000_0060;
        endcase
    endfunction

    function automatic logic [2:0] alg_code(input int idx);
        return 3'(idx + 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual still running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] src, dst, key, len, cmd;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rd(A_STS, v);   check("R1 status in reset", v, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(A_STS, v);   check("R1 status after reset", v, 32'h0);
        rd(A_SRC, v);   check("R1 src after reset", v, 32'h0);
        rd(A_CMD, v);   check("R1 cmd after reset", v, 32'h0);
        check("R1 dp_start after reset", 32'(dp_start), 32'h0);

        // R2 readback and unmapped offsets
        wr(A_SRC, 32'h8000_1000); wr(A_DST, 32'h8000_2000);
        wr(A_KEY, 32'h8000_3000); wr(A_LEN, 32'h0000_0040);
        rd(A_SRC, v); check("R2 src readback", v, 32'h8000_1000);
        rd(A_DST, v); check("R2 dst readback", v, 32'h8000_2000);
        rd(A_KEY, v); check("R2 key readback", v, 32'h8000_3000);
        rd(A_LEN, v); check("R2 len readback", v, 32'h0000_0040);
        rd(8'h00, v); check("R2 unmapped 0x00", v, 32'h0);
        rd(8'h18, v); check("R2 unmapped 0x18", v, 32'h0);
        rd(8'h34, v); check("R2 unmapped 0x34", v, 32'h0);

        // R10 unsupported encodings: none, bit10 alone
        wr(A_CMD, 32'h0000_0008);
        check("R10 no start", 32'(dp_start), 32'h0);
        rd(A_STS, v); check("R10 done set, busy clear", v, 32'h0000_0200);
        rd(A_CMD, v); check("R2 cmd readback", v, 32'h0000_0008);
        wr(A_STS, 32'h0000_0200);
        rd(A_STS, v); check("R8 w1c clears done", v, 32'h0);
        wr(A_CMD, 32'h0000_0400);
        check("R10 bit10 alone no start", 32'(dp_start), 32'h0);
        rd(A_STS, v); check("R10 bit10 alone done", v, 32'h0000_0200);
        wr(A_STS, 32'hFFFF_FDFF);
        rd(A_STS, v); check("R8 write of zero bit9 keeps done", v, 32'h0000_0200);

        // R7 done while idle
        wr(A_STS, 32'h0000_0200);
        pulse_done();
        rd(A_STS, v); check("R7 idle done ignored", v, 32'h0);

        // random jobs
        for (int it = 0; it < 40; it++) begin
            int idx;
            int lat;
            idx = $urandom_range(0, 4);
            src = $urandom; dst = $urandom; key = $urandom; len = $urandom;
            cmd = alg_bits(idx) | ({31'h0, 1'($urandom)} << 3)
                                | ({31'h0, 1'($urandom)} << 2)
                                | ({31'h0, 1'($urandom)} << 18);
            wr(A_STS, 32'h0000_0200);
            rd(A_STS, v); check("R8 cleared before launch", v, 32'h0);
            wr(A_SRC, src); wr(A_DST, dst); wr(A_KEY, key); wr(A_LEN, len);
            wr(A_CMD, cmd);
            check("R3 start pulse", 32'(dp_start), 32'h1);
            rd(A_STS, v); check("R3 busy after launch", v, 32'h1);
            check("R4 algo code", 32'(dp_algo), 32'(alg_code(idx)));
            check("R5 src", dp_src_addr, src);
            check("R5 dst", dp_dst_addr, dst);
            check("R5 key", dp_key_addr, key);
            check("R5 len", dp_len, len);
            check("R5 be flag", 32'(dp_be_out), 32'(cmd[3]));
            check("R5 md5 flag", 32'(dp_md5_le), 32'(cmd[2]));
            check("R5 sg flag", 32'(dp_sg_mode), 32'(cmd[18]));
            wr(A_SRC, ~src);
            check("R3 start one cycle", 32'(dp_start), 32'h0);
            check("R5 src held while busy", dp_src_addr, src);
            rd(A_SRC, v); check("R2 src rewritten", v, ~src);
            if (it % 3 == 0) begin
                wr(A_CMD, alg_bits((idx + 1) % 5));
                check("R6 no restart", 32'(dp_start), 32'h0);
                rd(A_CMD, v); check("R6 cmd kept", v, cmd);
                rd(A_STS, v); check("R6 still busy", v, 32'h1);
            end
            lat = $urandom_range(0, 4);
            repeat (lat) @(negedge clk);
            rd(A_STS, v); check("R7 busy until done", v, 32'h1);
            pulse_done();
            rd(A_STS, v); check("R7 done ends job", v, 32'h0000_0200);
        end

        // R8 completion and clear in the same cycle: set wins
        wr(A_STS, 32'h0000_0200);
        wr(A_CMD, alg_bits(2));
        @(negedge clk);
        dp_done   = 1'b1;
        reg_wr    = 1'b1;
        reg_addr  = A_STS;
        reg_wdata = 32'h0000_0200;
        @(negedge clk);
        dp_done = 1'b0;
        reg_wr  = 1'b0;
        rd(A_STS, v); check("R8 set wins over clear", v, 32'h0000_0200);

        // R9 sticky overflow
        @(negedge clk);
        dp_overflow = 1'b1;
        @(negedge clk);
        dp_overflow = 1'b0;
        rd(A_STS, v); check("R9 overflow set", v, 32'h0080_0200);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); check("R9 overflow survives write", v, 32'h0080_0000);
        repeat (3) @(negedge clk);
        rd(A_STS, v); check("R9 overflow holds", v, 32'h0080_0000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(A_STS, v); check("R9 reset clears overflow", v, 32'h0);
        rd(A_LEN, v); check("R1 len cleared by reset", v, 32'h0);

        summary();
        $finish;
    end

endmodule